// File: doc/BRIEF.md
# Parallel NOR Flash Command and Status Controller

This block sits between the host bus of a byte-wide parallel NOR flash and its internal program/erase engine. The flash has a 17-bit byte address, an 8-bit data bus and four equal 32 KB sectors. The host drives active-low chip enable, write enable and output enable. The controller decodes those write cycles into commands: byte program, chip erase, sector erase, erase suspend and erase resume. For each accepted command it latches the address and data and hands the operation to the engine.

While an operation is in progress, host reads return a status byte instead of array data. The status byte carries a polarity bit and two alternating bits that the host polls to detect completion. The array contents come from outside on `arr_rdata`, and this value is the byte at the current host address.

Operations leave the controller through a valid/ready channel. `op_valid` rises with `op_erase`, `op_addr`, `op_data` and `op_sect_mask`. These fields stay stable for as long as `op_ready` is low, and the launch is consumed in the cycle where both `op_valid` and `op_ready` are high. The engine signals completion with a one-cycle `op_done` pulse. While `eng_hold` is high, the engine keeps the erase paused.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After reset, `rdata` is 0, `op_valid` and `eng_hold` are 0, and a host read returns `arr_rdata`.
- R2: The program sequence is four writes: 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@target. Only address bits [10:0] are compared. The sequence raises `op_valid` with `op_erase`=0, `op_addr`=target and `op_data`=data, and these are held until `op_ready` is high.
- R3: A read during a program returns a status byte with these bits: bit7 is the inverse of written bit7, bit6 alternates and reads 1 first, bit2 is 1, and all other bits are 0.
- R4: After `op_done`, the controller is back in array-read mode and reads return `arr_rdata`.
- R5: Two erase sequences are decoded, both starting with 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA. A final 0x10@0x555 launches a chip erase whose `op_sect_mask` is every unprotected sector. A final 0x30 at a sector address launches a sector erase whose mask is one-hot at address bits [16:15].
- R6: A read during an erase returns bit7=0 and an alternating bit6. Bit2 alternates for addresses in a sector being erased and reads 1 elsewhere.
- R7: A single write of 0xB0 during an erase suspends it and raises `eng_hold`. While suspended, reads of sectors not being erased return array data. Reads of a sector being erased return bit7=1 with bit6 and bit2 alternating.
- R8: While suspended, a program to an unprotected sector that is not being erased is launched and reports program status. Its `op_done` returns the controller to the suspended state. A single 0x30 write then resumes the erase and drops `eng_hold`.
- R9: A program or sector erase aimed at a protected sector is not launched. A chip erase with every sector protected is not launched either.
- R10: A write that breaks a sequence, including 0xF0, returns the decoder to idle without launching anything. A later complete sequence still works.
- R11: Bit6 and bit2 advance once per read start. A read starts when output enable falls while chip enable is low, or when chip enable falls while output enable is low. Holding a read open, or toggling output enable with chip enable high, does not advance them.
- R12: Command writes other than suspend that arrive during an erase launch nothing and leave the operation fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data or status, captured at read start |
| arr_rdata | input | 8 | Array byte at the current host address |
| sect_prot | input | 4 | Per-sector protection flags |
| op_valid | output | 1 | Operation launch valid |
| op_ready | input | 1 | Engine accepts the launch |
| op_erase | output | 1 | 1 for erase, 0 for program |
| op_addr | output | 17 | Latched operation address |
| op_data | output | 8 | Latched program data |
| op_sect_mask | output | 4 | Sectors selected for erase |
| op_done | input | 1 | Engine completion pulse |
| eng_hold | output | 1 | Erase paused (suspended) |

## Verification
The hardest state to reach is a program nested inside a suspended erase, where the alternating bits must keep their phase across the nesting. The stimulus starts a sector erase and reads it once. It then suspends the erase, reads both a sector being erased and a free sector, and tries a program into the sector being erased, which must be refused. Next it programs a free sector, completes that program, reads the erasing sector again and resumes. The bench predicts every status byte from its own count of read starts. Read starts are also driven in all three forms: output enable first, chip enable first, and a held-open read.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [2:0] {ST_READ, ST_PROG, ST_ERASE, ST_SUSP, ST_SPROG} op_state_t;
  typedef enum logic [2:0] {D_IDLE, D_U1, D_U2, D_PGM, D_ES, D_E1, D_E2} dec_state_t;
  localparam int UNLK_W = 11;
  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [UNLK_W-1:0] KEY_ADR1 = 11'h555;
  localparam logic [UNLK_W-1:0] KEY_ADR2 = 11'h2AA;
endpackage

// File: rtl/fcc_bus_edge.sv
module fcc_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_evt,
  output logic rd_evt
);
  logic wr_on, rd_on, wr_on_q, rd_on_q;

  assign wr_on  = !ce_n && !we_n;
  assign rd_on  = !ce_n && !oe_n;
  assign wr_evt = wr_on && !wr_on_q;
  assign rd_evt = rd_on && !rd_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_on_q <= 1'b0;
      rd_on_q <= 1'b0;
    end else begin
      wr_on_q <= wr_on;
      rd_on_q <= rd_on;
    end
  end

  // R11
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_evt |=> !rd_evt);
endmodule

// File: rtl/fcc_decoder.sv
module fcc_decoder
  import flash_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [UNLK_W-1:0] key_addr,
  input  logic [7:0]        wdata,
  output logic              c_prog,
  output logic              c_chip,
  output logic              c_sect,
  output logic              c_susp,
  output logic              c_resume
);
  dec_state_t ds, ds_nx;
  logic hit1, hit2;

  assign hit1 = (key_addr == KEY_ADR1);
  assign hit2 = (key_addr == KEY_ADR2);

  always_comb begin
    ds_nx    = D_IDLE;
    c_prog   = 1'b0;
    c_chip   = 1'b0;
    c_sect   = 1'b0;
    c_susp   = 1'b0;
    c_resume = 1'b0;
    unique case (ds)
      D_IDLE: begin
        if (hit1 && wdata == CMD_KEY1) ds_nx = D_U1;
        else if (wdata == CMD_SUSP)    c_susp = wr_evt;
        else if (wdata == CMD_RESUME)  c_resume = wr_evt;
      end
      D_U1: if (hit2 && wdata == CMD_KEY2) ds_nx = D_U2;
      D_U2: begin
        if (hit1 && wdata == CMD_PROG)        ds_nx = D_PGM;
        else if (hit1 && wdata == CMD_ESETUP) ds_nx = D_ES;
      end
      D_PGM: c_prog = wr_evt;
      D_ES: if (hit1 && wdata == CMD_KEY1) ds_nx = D_E1;
      D_E1: if (hit2 && wdata == CMD_KEY2) ds_nx = D_E2;
      D_E2: begin
        if (hit1 && wdata == CMD_CHIP) c_chip = wr_evt;
        else if (wdata == CMD_SECT)    c_sect = wr_evt;
      end
      default: ds_nx = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ds <= D_IDLE;
    else if (wr_evt) ds <= ds_nx;
  end

  // R10
  reset_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wdata == CMD_RESET && ds != D_PGM) |=> ds == D_IDLE);
endmodule

// File: rtl/fcc_tracker.sv
module fcc_tracker
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SECT_N = 4,
  localparam int SECT_W = $clog2(SECT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_prog,
  input  logic              c_chip,
  input  logic              c_sect,
  input  logic              c_susp,
  input  logic              c_resume,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SECT_N-1:0] sect_prot,
  input  logic              op_ready,
  input  logic              op_done,
  output op_state_t         st,
  output logic              op_valid,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [SECT_N-1:0] op_sect_mask,
  output logic              eng_hold
);
  logic [SECT_W-1:0] cmd_sect;
  logic [SECT_N-1:0] cmd_hot, free_mask;
  logic              cmd_prot;

  assign cmd_sect  = addr[ADDR_W-1 -: SECT_W];
  assign cmd_hot   = SECT_N'(1) << cmd_sect;
  assign cmd_prot  = sect_prot[cmd_sect];
  assign free_mask = ~sect_prot;
  assign eng_hold  = (st == ST_SUSP) || (st == ST_SPROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_READ;
      op_valid     <= 1'b0;
      op_erase     <= 1'b0;
      op_addr      <= '0;
      op_data      <= '0;
      op_sect_mask <= '0;
    end else begin
      if (op_valid && op_ready) op_valid <= 1'b0;
      unique case (st)
        ST_READ: begin
          if (c_prog && !cmd_prot) begin
            st <= ST_PROG; op_valid <= 1'b1; op_erase <= 1'b0;
            op_addr <= addr; op_data <= wdata;
          end else if (c_chip && free_mask != '0) begin
            st <= ST_ERASE; op_valid <= 1'b1; op_erase <= 1'b1;
            op_addr <= addr; op_sect_mask <= free_mask;
          end else if (c_sect && !cmd_prot) begin
            st <= ST_ERASE; op_valid <= 1'b1; op_erase <= 1'b1;
            op_addr <= addr; op_sect_mask <= cmd_hot;
          end
        end
        ST_PROG: if (op_done) st <= ST_READ;
        ST_ERASE: begin
          if (op_done) begin
            st <= ST_READ; op_sect_mask <= '0;
          end else if (c_susp) st <= ST_SUSP;
        end
        ST_SUSP: begin
          if (c_prog && !cmd_prot && !op_sect_mask[cmd_sect]) begin
            st <= ST_SPROG; op_valid <= 1'b1; op_erase <= 1'b0;
            op_addr <= addr; op_data <= wdata;
          end else if (c_resume) st <= ST_ERASE;
        end
        ST_SPROG: if (op_done) begin
          st <= ST_SUSP; op_erase <= 1'b1;
        end
        default: st <= ST_READ;
      endcase
    end
  end

  // R2
  launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_addr) && $stable(op_data) && $stable(op_erase)));
  // R9
  prog_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && !op_erase) |-> !sect_prot[op_addr[ADDR_W-1 -: SECT_W]]);
  // R9
  erase_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && op_erase) |-> ((op_sect_mask & sect_prot) == '0));
  // R7
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hold |-> (op_sect_mask != '0));
endmodule

// File: rtl/fcc_status.sv
module fcc_status
  import flash_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SECT_N = 4,
  localparam int SECT_W = $clog2(SECT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [DATA_W-1:0] arr_rdata,
  input  op_state_t         st,
  input  logic              prog_bit7,
  input  logic [SECT_N-1:0] erase_mask,
  output logic [DATA_W-1:0] rdata
);
  logic tog6, tog2, show, use2, b7;
  logic [DATA_W-1:0] stat;

  always_comb begin
    show = 1'b0; use2 = 1'b0; b7 = 1'b0;
    unique case (st)
      ST_PROG, ST_SPROG: begin show = 1'b1; b7 = !prog_bit7; end
      ST_ERASE: begin show = 1'b1; use2 = erase_mask[rd_sect]; end
      ST_SUSP: begin show = erase_mask[rd_sect]; use2 = 1'b1; b7 = 1'b1; end
      default: show = 1'b0;
    endcase
    stat    = '0;
    stat[7] = b7;
    stat[6] = !tog6;
    stat[2] = use2 ? !tog2 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; tog6 <= 1'b0; tog2 <= 1'b0;
    end else begin
      if (rd_evt) begin
        rdata <= show ? stat : arr_rdata;
        if (show)         tog6 <= !tog6;
        if (show && use2) tog2 <= !tog2;
      end
      if (st == ST_READ) begin
        tog6 <= 1'b0; tog2 <= 1'b0;
      end
    end
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_evt |=> $stable(rdata));
  // R3
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && st == ST_PROG) |=> rdata[7] != prog_bit7);
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SECT_N = 4,
  localparam int SECT_W = $clog2(SECT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [SECT_N-1:0] sect_prot,
  output logic              op_valid,
  input  logic              op_ready,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [SECT_N-1:0] op_sect_mask,
  input  logic              op_done,
  output logic              eng_hold
);
  logic wr_evt, rd_evt;
  logic c_prog, c_chip, c_sect, c_susp, c_resume;
  op_state_t st;

  fcc_bus_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  fcc_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .key_addr(addr[UNLK_W-1:0]),
    .wdata(wdata[7:0]), .c_prog(c_prog), .c_chip(c_chip), .c_sect(c_sect),
    .c_susp(c_susp), .c_resume(c_resume)
  );

  fcc_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_N(SECT_N)) u_trk (
    .clk(clk), .rst_n(rst_n), .c_prog(c_prog), .c_chip(c_chip), .c_sect(c_sect),
    .c_susp(c_susp), .c_resume(c_resume), .addr(addr), .wdata(wdata),
    .sect_prot(sect_prot), .op_ready(op_ready), .op_done(op_done), .st(st),
    .op_valid(op_valid), .op_erase(op_erase), .op_addr(op_addr), .op_data(op_data),
    .op_sect_mask(op_sect_mask), .eng_hold(eng_hold)
  );

  fcc_status #(.DATA_W(DATA_W), .SECT_N(SECT_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .rd_sect(addr[ADDR_W-1 -: SECT_W]),
    .arr_rdata(arr_rdata), .st(st), .prog_bit7(op_data[7]),
    .erase_mask(op_sect_mask), .rdata(rdata)
  );
endmodule

// File: tb/tb_flash_cmd_ctl.sv
module tb_flash_cmd_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0, arr_rdata = '0, rdata, op_data;
  logic [3:0]  sect_prot = '0, op_sect_mask;
  logic op_valid, op_ready = 1'b1, op_erase, op_done = 1'b0, eng_hold;
  logic [16:0] op_addr;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #10 clk = !clk;

  flash_cmd_ctl dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .arr_rdata(arr_rdata), .sect_prot(sect_prot),
    .op_valid(op_valid), .op_ready(op_ready), .op_erase(op_erase), .op_addr(op_addr),
    .op_data(op_data), .op_sect_mask(op_sect_mask), .op_done(op_done), .eng_hold(eng_hold)
  );

  localparam logic [24:0] PVEC [6] = '{
    {17'h00012, 8'h81}, {17'h0ABCD, 8'h7E}, {17'h10555, 8'hC3},
    {17'h1FFFF, 8'h00}, {17'h08000, 8'hFF}, {17'h17777, 8'h2A}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, input int hold, output logic [7:0] r);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (hold) @(negedge clk);
    r = rdata; oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_ce_last(input logic [16:0] a, output logic [7:0] r);
    @(negedge clk); addr = a; oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b0;
    repeat (3) @(negedge clk);
    r = rdata; oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [16:0] a, input logic [7:0] d);
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55); wr(17'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55); wr(17'h555, 8'h80);
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 op_valid", op_valid, 1'b0);
    chk("R1 eng_hold", eng_hold, 1'b0);
    rst_n = 1'b1;
    arr_rdata = 8'h3C; rd(17'h00040, 3, v); chk("R1 array read", v, 8'h3C);

    // R2 R3 R4 vector walk
    op_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      logic [16:0] a; logic [7:0] d;
      a = PVEC[i][24:8]; d = PVEC[i][7:0];
      prog(a, d);
      repeat (2) @(negedge clk);
      chk("R2 op_valid held", op_valid, 1'b1);
      chk("R2 op_addr", op_addr, a);
      chk("R2 op_data", op_data, d);
      chk("R2 op_erase", op_erase, 1'b0);
      op_ready = 1'b1; @(negedge clk); @(negedge clk);
      chk("R2 consumed", op_valid, 1'b0);
      op_ready = 1'b0;
      rd(a, 3, v); chk("R3 first status", v, {~d[7], 1'b1, 3'b000, 1'b1, 2'b00});
      rd(a, 3, v); chk("R3 second status", v, {~d[7], 1'b0, 3'b000, 1'b1, 2'b00});
      done_pulse();
      arr_rdata = d; rd(a, 3, v); chk("R4 data after done", v, d);
    end
    op_ready = 1'b1;

    // R5 R6 R12 chip erase with sector 2 protected
    sect_prot = 4'b0100;
    erase_pre(); wr(17'h555, 8'h10);
    chk("R5 chip mask", op_sect_mask, 4'b1011);
    chk("R5 chip erase kind", op_erase, 1'b1);
    rd(17'h00100, 3, v); chk("R6 in-mask read 1", v, 8'h44);
    rd(17'h00100, 3, v); chk("R6 in-mask read 2", v, 8'h00);
    rd(17'h10100, 3, v); chk("R6 outside mask", v, 8'h44);
    prog(17'h00200, 8'h11);
    repeat (2) @(negedge clk);
    chk("R12 no launch", op_valid, 1'b0);
    chk("R12 kind kept", op_erase, 1'b1);
    chk("R12 mask kept", op_sect_mask, 4'b1011);
    rd(17'h08100, 3, v); chk("R12 still erasing", v, 8'h04);
    done_pulse();
    arr_rdata = 8'hE1; rd(17'h08100, 3, v); chk("R4 after erase", v, 8'hE1);

    // R5 R7 R8 sector erase, suspend, nested program, resume
    sect_prot = 4'b0000;
    erase_pre(); wr(17'h08000, 8'h30);
    chk("R5 sector mask", op_sect_mask, 4'b0010);
    rd(17'h08010, 3, v); chk("R6 sector status", v, 8'h44);
    wr(17'h00000, 8'hB0);
    chk("R7 hold", eng_hold, 1'b1);
    arr_rdata = 8'h5A; rd(17'h18000, 3, v); chk("R7 free sector data", v, 8'h5A);
    rd(17'h08010, 3, v); chk("R7 erasing sector status", v, 8'h80);
    prog(17'h08020, 8'h12);
    @(negedge clk);
    chk("R8 refuse erasing sector", op_valid, 1'b0);
    rd(17'h18000, 3, v); chk("R8 still suspended", v, 8'h5A);
    op_ready = 1'b0;
    prog(17'h10010, 8'h81);
    @(negedge clk);
    chk("R8 suspended launch", op_valid, 1'b1);
    chk("R8 suspended kind", op_erase, 1'b0);
    chk("R8 suspended addr", op_addr, 17'h10010);
    op_ready = 1'b1; @(negedge clk);
    rd(17'h10010, 3, v); chk("R8 program status", v, 8'h44);
    done_pulse();
    chk("R8 back to suspend", eng_hold, 1'b1);
    rd(17'h08010, 3, v); chk("R8 erasing sector again", v, 8'h84);
    wr(17'h00000, 8'h30);
    chk("R8 resume", eng_hold, 1'b0);
    rd(17'h08010, 3, v); chk("R8 resumed status", v, 8'h40);
    done_pulse();
    arr_rdata = 8'h0F; rd(17'h08010, 3, v); chk("R4 after sector erase", v, 8'h0F);

    // R9 protection
    sect_prot = 4'b0001; arr_rdata = 8'h99;
    prog(17'h00123, 8'h55); @(negedge clk);
    chk("R9 protected program", op_valid, 1'b0);
    rd(17'h00123, 3, v); chk("R9 array after program", v, 8'h99);
    erase_pre(); wr(17'h00000, 8'h30); @(negedge clk);
    chk("R9 protected sector erase", op_valid, 1'b0);
    sect_prot = 4'b1111;
    erase_pre(); wr(17'h00555, 8'h10); @(negedge clk);
    chk("R9 all protected chip erase", op_valid, 1'b0);
    rd(17'h00123, 3, v); chk("R9 array after erase", v, 8'h99);
    sect_prot = 4'b0000;

    // R10 broken sequences
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h12); wr(17'h2AA, 8'h55); wr(17'h555, 8'hA0);
    wr(17'h00123, 8'h77); @(negedge clk);
    chk("R10 broken key", op_valid, 1'b0);
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55); wr(17'h555, 8'hF0);
    wr(17'h555, 8'hA0); wr(17'h00123, 8'h77); @(negedge clk);
    chk("R10 reset command", op_valid, 1'b0);
    rd(17'h00123, 3, v); chk("R10 array kept", v, 8'h99);
    op_ready = 1'b0;
    prog(17'h00124, 8'h66); @(negedge clk);
    chk("R10 recovery", op_valid, 1'b1);
    op_ready = 1'b1; @(negedge clk);

    // R11 read start forms, program of 0x66 in progress
    rd(17'h00124, 3, v); chk("R11 first read", v, 8'hC4);
    rd(17'h00124, 20, v); chk("R11 held read", v, 8'h84);
    rd_ce_last(17'h00124, v); chk("R11 ce-last read", v, 8'hC4);
    @(negedge clk); oe_n = 1'b0; repeat (3) @(negedge clk); oe_n = 1'b1; @(negedge clk);
    rd(17'h00124, 3, v); chk("R11 oe without ce", v, 8'h84);
    done_pulse();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule